// File: doc/BRIEF.md
# SPI Master Controller

This block is a single-device SPI master driven from a small 32-bit register bus. Software programs one configuration word that picks the serial clock rate, the clock polarity and phase, the bit order, whether a chip-select pin is driven, and the level at which that pin is active. The word also holds an enable bit. While the block is enabled and idle, a write to the data register starts one full-duplex 8-bit exchange. The byte goes out on MOSI while 8 bits are taken in from MISO.

The status register shows whether an exchange is in flight. Software polls it, and when it reads 0 it reads the received byte from the data register. The bus has no back-pressure: each access completes in the cycle it is presented. A write that the block cannot take is dropped. This covers a data write while busy or disabled, and a configuration write while busy. Read data is combinational from the address.

Top module: `spi_ctl`

## Requirements
- R1: The register offsets are 0x0 for configuration, 0x4 for status and 0x8 for data. Any other offset reads 0, and writes to it (or to status) change nothing.
- R2: After reset the configuration reads 0x064. That is scale 4, mode 0, MSB-first, chip select in use, active-low, disabled.
- R3: Configuration fields are: scale in bits 2:0, CPHA in bit 3, CPOL in bit 4, MSB-first in bit 5, chip-select use in bit 6, active-high chip select in bit 7, and enable in bit 8. A read returns bits 8:0 exactly as last written, with bits 31:9 reading 0. A configuration write while busy is ignored.
- R4: A data write taken while enabled and idle sets status bit 0 from the next cycle. The bit stays set for exactly 16*H cycles, where H = 2^(scale-1), and H = 1 for scale 0.
- R5: A data write while disabled or while busy starts nothing. It also does not alter the byte in flight.
- R6: An exchange sends bits 7:0 of the written word on MOSI and collects 8 bits from MISO. Reading the data register then returns the collected byte in bits 7:0.
- R7: With bit 5 set, bit 7 goes first in both directions. With bit 5 clear, bit 0 goes first.
- R8: SCK rests at the CPOL level whenever the block is idle. With CPHA 0, the first bit is on MOSI before the first edge, and both sides sample on leading edges. With CPHA 1, MOSI changes on leading edges and both sides sample on trailing edges.
- R9: The first SCK edge comes H cycles after the start. SCK then toggles every H cycles for exactly 16 edges.
- R10: Chip select rests at the inverse of bit 7. While busy with bit 6 set, it is held at the level of bit 7 for the whole exchange. With bit 6 clear, it never leaves its resting level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs | output | 1 | Chip select |

## Verification
The checker computes the expected busy length from the live scale field. It counts on the configuration staying frozen for the whole exchange, and it counts on reset being applied before the first access. The checker also assumes that MISO settles before each sampling edge. The bench device model changes MISO only on falling system-clock edges, at least one cycle away from the next master sampling edge. The bench holds each bus write for one cycle, and it places its injected busy-time writes only inside exchanges whose length it knows.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int CFG_W   = 9;
  localparam int SCALE_W = 3;
  localparam int OFS_CFG  = 'h0;
  localparam int OFS_STAT = 'h4;
  localparam int OFS_DATA = 'h8;

  typedef struct packed {
    logic               en;
    logic               cs_hi;
    logic               use_cs;
    logic               msb;
    logic               cpol;
    logic               cpha;
    logic [SCALE_W-1:0] scale;
  } cfg_t;

  localparam cfg_t CFG_RST = '{en: 1'b0, cs_hi: 1'b0, use_cs: 1'b1, msb: 1'b1,
                               cpol: 1'b0, cpha: 1'b0, scale: 3'd4};
endpackage

// File: rtl/spi_cfg_reg.sv
module spi_cfg_reg
  import spi_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= CFG_RST;
    else if (wr_en) cfg_q <= cfg_t'(wdata);
  end
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int SCALE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);
  localparam int CNT_W = (1 << SCALE_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [CNT_W:0]   pow;

  // half period H = 2^(scale-1), with scale 0 folded onto H = 1
  always_comb begin
    pow = '0;
    if (scale != '0) pow = {{CNT_W{1'b0}}, 1'b1} << (scale - 1'b1);
    lim = (scale == '0) ? '0 : CNT_W'(pow - 1'b1);
  end

  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng
  import spi_ctl_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  cfg_t              cfg,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int EDGES  = 2 * BYTE_W;
  localparam int EDGE_W = $clog2(EDGES);

  logic [EDGE_W-1:0] ecnt;
  logic [BYTE_W-1:0] tx_sr, rx_sr, rx_next;
  logic              sck_ph, leading, sample, launch, last;

  function automatic logic out_bit(logic [BYTE_W-1:0] v, logic msb);
    return msb ? v[BYTE_W-1] : v[0];
  endfunction

  function automatic logic [BYTE_W-1:0] shifted(logic [BYTE_W-1:0] v, logic msb);
    return msb ? {v[BYTE_W-2:0], 1'b0} : {1'b0, v[BYTE_W-1:1]};
  endfunction

  assign leading = ~ecnt[0];
  assign last    = (ecnt == EDGE_W'(EDGES - 1));
  assign sample  = tick && (leading ^ cfg.cpha);
  assign launch  = tick && !(leading ^ cfg.cpha) && !last;
  assign rx_next = cfg.msb ? {rx_sr[BYTE_W-2:0], miso} : {miso, rx_sr[BYTE_W-1:1]};
  assign sck_o   = sck_ph ^ cfg.cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      ecnt    <= '0;
      sck_ph  <= 1'b0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      mosi_o  <= 1'b0;
      rx_byte <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      ecnt   <= '0;
      sck_ph <= 1'b0;
      rx_sr  <= '0;
      if (cfg.cpha) begin
        tx_sr <= tx_byte;
      end else begin
        mosi_o <= out_bit(tx_byte, cfg.msb);
        tx_sr  <= shifted(tx_byte, cfg.msb);
      end
    end else if (tick) begin
      sck_ph <= ~sck_ph;
      if (sample) rx_sr <= rx_next;
      if (launch) begin
        mosi_o <= out_bit(tx_sr, cfg.msb);
        tx_sr  <= shifted(tx_sr, cfg.msb);
      end
      if (last) begin
        busy    <= 1'b0;
        ecnt    <= '0;
        rx_byte <= sample ? rx_next : rx_sr;
      end else begin
        ecnt <= ecnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
  import spi_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);

  cfg_t              cfg_q;
  logic              busy, tick, wr_cfg, start;
  logic [BYTE_W-1:0] rx_byte;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CFG_W];
  assign wr_cfg = bus_we && (bus_addr == A_CFG) && !busy;
  assign start  = bus_we && (bus_addr == A_DATA) && cfg_q.en && !busy;

  spi_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_cfg),
    .wdata (bus_wdata[CFG_W-1:0]),
    .cfg_q (cfg_q)
  );

  spi_clk_div #(.SCALE_W(SCALE_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .scale (cfg_q.scale),
    .tick  (tick)
  );

  spi_shift_eng #(.BYTE_W(BYTE_W)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tx_byte (bus_wdata[BYTE_W-1:0]),
    .cfg     (cfg_q),
    .tick    (tick),
    .miso    (spi_miso),
    .busy    (busy),
    .sck_o   (spi_sck),
    .mosi_o  (spi_mosi),
    .rx_byte (rx_byte)
  );

  assign spi_cs = (busy && cfg_q.use_cs) ? cfg_q.cs_hi : ~cfg_q.cs_hi;

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = DATA_W'(cfg_q);
      A_STAT:  bus_rdata = DATA_W'(busy);
      A_DATA:  bus_rdata = DATA_W'(rx_byte);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_ctl_checker.sv
module spi_ctl_checker #(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [8:0]        cfg,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic              sck,
  input logic              cs
);
  logic [11:0] busy_cnt, exp_len;
  logic [5:0]  tog_cnt;
  logic        sck_q;
  logic        unused_cfg;

  assign unused_cfg = cfg[3] ^ cfg[5];
  assign exp_len = (cfg[2:0] == 3'd0) ? 12'd16 : (12'd16 << (cfg[2:0] - 3'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      tog_cnt  <= '0;
      sck_q    <= 1'b0;
    end else begin
      sck_q    <= sck;
      busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
      if (!busy)            tog_cnt <= '0;
      else if (sck != sck_q) tog_cnt <= tog_cnt + 1'b1;
    end
  end

  // R4: busy lasts 16*H cycles
  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == exp_len));

  // R9: exactly 2*BYTE_W edges per exchange, last one on the closing cycle
  p_edge_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ((tog_cnt == 6'(2 * BYTE_W - 1)) && (sck != sck_q)));

  // R3: configuration frozen while busy
  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && we && addr == ADDR_W'(0)) |=> (cfg == $past(cfg)));

  // R5: disabled data write starts nothing
  p_no_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && we && addr == ADDR_W'(8) && !cfg[8]) |=> !busy);

  // R8: SCK rests at CPOL when idle
  p_sck_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cfg[4]));

  // R10: clock activity happens under an active chip select
  p_cs_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (sck != sck_q) && cfg[6]) |-> (cs == cfg[7]));
endmodule

bind spi_ctl spi_ctl_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (busy),
  .cfg   (cfg_q),
  .we    (bus_we),
  .addr  (bus_addr),
  .sck   (spi_sck),
  .cs    (spi_cs)
);

// File: tb/spi_ctl_bench.sv
module spi_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h4;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sck, mosi, miso, cs;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_ctl u_spi_ctl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso), .spi_cs(cs)
  );

  int n_chk = 0;
  int n_bad = 0;

  // device model: samples and advances on the master's sampling edges
  logic [7:0] s_tx = '0, s_rx = '0;
  logic [3:0] s_idx = '0;
  logic       s_on = 1'b0, s_prev = 1'b0;
  logic       b_cpol = 1'b0, b_cpha = 1'b0, b_msb = 1'b1;
  logic [2:0] bi;

  assign bi   = b_msb ? 3'(4'd7 - s_idx) : s_idx[2:0];
  assign miso = (s_idx < 4'd8) ? s_tx[bi] : 1'b0;

  always @(negedge clk) begin
    if (s_on && (sck !== s_prev)) begin
      if ((sck !== b_cpol) ^ b_cpha) begin
        if (s_idx < 4'd8) s_rx[bi] = mosi;
        s_idx = s_idx + 4'd1;
      end
    end
    s_prev = sck;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 4'h4;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = 4'h4;
  endtask

  function automatic int half_of(input logic [2:0] s);
    return (s == 3'd0) ? 1 : (1 << (s - 3'd1));
  endfunction

  // inj: 0 none, 1 data write while busy, 2 config write while busy
  task automatic xfer(input logic [8:0] c, input logic [7:0] tx, input logic [7:0] stx, input int inj);
    logic [31:0] r;
    int   n, first, tog, h;
    logic sl, cs_exp, cs_ok;
    h = half_of(c[2:0]);
    wr(4'h0, {23'h0, c});
    b_cpol = c[4]; b_cpha = c[3]; b_msb = c[5];
    s_tx = stx; s_rx = '0; s_idx = '0; s_prev = sck; s_on = 1'b1;
    cs_exp = c[6] ? c[7] : ~c[7];
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'h8; bus_wdata = {24'h0, tx};
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 4'h4;
    #1;
    n = 0; first = -1; tog = 0; sl = c[4]; cs_ok = 1'b1;
    while (bus_rdata[0] === 1'b1 && n < 5000) begin
      if (sck !== sl) begin
        tog++;
        if (first < 0) first = n;
        sl = sck;
      end
      if (cs !== cs_exp) cs_ok = 1'b0;
      n++;
      if (n == 3 && inj == 1) begin bus_we = 1'b1; bus_addr = 4'h8; bus_wdata = {24'h0, ~tx}; end
      if (n == 3 && inj == 2) begin bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = {23'h0, c ^ 9'h0D8}; end
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 4'h4;
      #1;
    end
    chk("R4 busy cycles", n, 16 * h);
    chk("R9 first edge delay", first, h);
    chk("R9 edges while busy", tog, 15);
    chk("R8 sck idle after", {31'h0, sck}, {31'h0, c[4]});
    chk("R10 cs during exchange", {31'h0, cs_ok}, 32'h1);
    chk("R10 cs after", {31'h0, cs}, {31'h0, ~c[7]});
    rd(4'h8, r);
    chk("R6 R7 byte from device", r, {24'h0, stx});
    chk("R6 R7 byte at device", {24'h0, s_rx}, {24'h0, tx});
    if (inj == 1) chk("R5 busy write dropped", {28'h0, s_idx}, 32'd8);
    if (inj == 2) begin
      rd(4'h0, r);
      chk("R3 config write while busy", r, {23'h0, c});
    end
    s_on = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r, prev;
    logic [8:0]  c;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(4'h0, r); chk("R2 config reset", r, 32'h064);
    rd(4'h4, r); chk("R1 status reset", r, 32'h0);
    rd(4'h8, r); chk("R1 data reset", r, 32'h0);
    rd(4'hC, r); chk("R1 unmapped read", r, 32'h0);
    chk("R10 cs idle at reset", {31'h0, cs}, 32'h1);
    chk("R8 sck idle at reset", {31'h0, sck}, 32'h0);

    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, r); chk("R3 readback all ones", r, 32'h1FF);
    for (int i = 0; i < 6; i++) begin
      c = 9'($urandom);
      wr(4'h0, {$urandom} & 32'hFFFF_FE00 | {23'h0, c});
      rd(4'h0, r); chk("R3 readback random", r, {23'h0, c});
    end
    wr(4'h0, 32'h064);
    wr(4'hC, 32'h1FF);
    wr(4'h4, 32'h1FF);
    rd(4'h0, r); chk("R1 stray writes ignored", r, 32'h064);

    // disabled: a data write does nothing
    rd(4'h8, prev);
    wr(4'h8, 32'hAA);
    rd(4'h4, r); chk("R5 disabled status", r, 32'h0);
    begin
      logic moved;
      moved = 1'b0;
      repeat (20) begin
        @(negedge clk); #1;
        if (sck !== 1'b0 || cs !== 1'b1) moved = 1'b1;
      end
      chk("R5 disabled pins quiet", {31'h0, moved}, 32'h0);
    end
    rd(4'h8, r); chk("R5 disabled data unchanged", r, prev);

    // directed: default timing, mode 0, MSB first, active-low select
    xfer(9'h164, 8'h1F, 8'hC5, 0);
    xfer(9'h164, 8'hA3, 8'h1F, 1);
    xfer(9'h1C2, 8'h9B, 8'h3C, 2);
    xfer(9'h118, 8'h81, 8'h7E, 0);
    xfer(9'h100, 8'h01, 8'h80, 0);

    for (int i = 0; i < 24; i++) begin
      c = {1'b1, 5'($urandom), 3'($urandom_range(0, 3))};
      xfer(c, 8'($urandom), 8'($urandom), 0);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule